// File: doc/BRIEF.md
# Idle Entry and Wakeup Controller

This block puts a small processor core into a low-power idle state and brings it out again. Software asks for idle by writing a one to the idle bit of the control word. From the next cycle the block holds the CPU stall output high, which freezes the core clock. On its own free-running clock it watches the interrupt latches together with their individual enable flags. When any latch is set and enabled, idle ends. The block then sends a one-cycle resume pulse to the core.

The master interrupt enable, sampled when the release happens, picks one of two ways to leave idle. With the master enable clear, the core continues at the instruction after the one that started idle. No interrupt is serviced, and the waking latch stays set until software clears it. With the master enable set, the block also raises a vector request in the same cycle as the resume pulse, together with the index of the waking source. The core services that interrupt first and then continues after the idle-start instruction.

The control word also holds a speed bit that selects one of two run modes. The mode in use before idle is the one in use after it, because the block ignores every control write while idle. A watchdog interrupt that arrives just before an idle request cancels the entry. The reset pin always ends idle and leaves the core in run mode 0.

Top module: `idle_wake_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears all state. After that edge, `cpu_stall`, `resume_pulse` and `vec_req` are 0 and `op_mode` is 2'b00 (run mode 0). This ends idle if it was active.
- R2: A control write with `ctl_idle`=1, made while not idle and not refused by R7, sets `cpu_stall` to 1 from the next cycle. `op_mode` then reads {1, speed}.
- R3: While idle, the block releases idle at a clock edge only if at least one bit has both `irq_latch` and `irq_enable` set. A latch whose enable is clear keeps the block in idle.
- R4: A release with `master_ie`=0 at the release edge gives `resume_pulse`=1 with `vec_req`=0 in the cycle after that edge.
- R5: A release with `master_ie`=1 gives `resume_pulse`=1 and `vec_req`=1 in the same cycle. `vec_idx` then holds the lowest bit index that is both latched and enabled.
- R6: In the cycle with `resume_pulse`=1, `cpu_stall` is 0 and `op_mode` reads {0, speed}, where speed is the value in force before idle began.
- R7: An idle request is refused if `wdt_irq` is 1 in the cycle of the write or in the cycle before it. `cpu_stall` then stays 0.
- R8: A write with `ctl_idle`=0 while not idle leaves `cpu_stall` at 0 and only loads the speed bit (`op_mode`[0] = `ctl_speed` from the next cycle). Any write while idle is ignored: both stall and speed stay unchanged.
- R9: `resume_pulse` lasts exactly one cycle. `vec_req` is never 1 without `resume_pulse`. Neither is 1 outside a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; it is never gated |
| rst_n | input | 1 | Synchronous active-low reset; this is the reset pin |
| ctl_wr | input | 1 | Strobe for a control word write |
| ctl_idle | input | 1 | Idle request bit of the written word |
| ctl_speed | input | 1 | Run-mode select bit of the written word |
| wdt_irq | input | 1 | Watchdog interrupt occurrence |
| irq_latch | input | NSRC | Interrupt latch vector |
| irq_enable | input | NSRC | Individual interrupt enable vector |
| master_ie | input | 1 | Master interrupt enable flag |
| cpu_stall | output | 1 | High while idle; freezes the core clock |
| resume_pulse | output | 1 | One-cycle pulse telling the core to continue |
| vec_req | output | 1 | Request to service the waking interrupt |
| vec_idx | output | IDXW | Index of the waking source, valid with vec_req |
| op_mode | output | 2 | {idle, speed}: current operating mode |

## Verification
Every result is registered, so each result appears one clock edge after the input that causes it. A write leads to the stall or speed change one cycle later, and a wake condition seen while idle leads to the resume pulse, vector request and index one cycle later. The refusal window covers the write cycle and the cycle before it. The bench drives its inputs on the falling edge and lets its reference model advance across the same rising edge as the design. It compares every output at the next falling edge, so each expectation is checked exactly in the cycle it becomes due.

// File: rtl/idle_pkg.sv
// Shared definitions for the idle entry and wakeup controller.
// Assumes op_mode is read as {idle, speed}.
package idle_pkg;
    typedef enum logic [1:0] {
        OPM_RUN0  = 2'b00,
        OPM_RUN1  = 2'b01,
        OPM_IDLE0 = 2'b10,
        OPM_IDLE1 = 2'b11
    } op_mode_t;

    function automatic op_mode_t make_mode(input logic idle, input logic speed);
        return op_mode_t'({idle, speed});
    endfunction
endpackage

// File: rtl/idle_wake_detect.sv
// Wake detector: masks the latch vector with the enable vector, reports
// whether any source is pending, and encodes the lowest pending index.
// Assumes NSRC >= 2. Purely combinational; the sequencer samples the result.
module idle_wake_detect #(
    parameter int NSRC = 8,
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] irq_latch,
    input  logic [NSRC-1:0] irq_enable,
    output logic            wake,
    output logic [IDXW-1:0] wake_idx
);
    logic [NSRC-1:0] hit;

    // Purpose: keep only the sources that are both latched and enabled.
    always_comb hit = irq_latch & irq_enable;

    // Purpose: OR-reduce the hits and find the lowest index (lowest index wins).
    always_comb begin
        wake     = |hit;
        wake_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hit[i]) wake_idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/idle_entry_guard.sv
// Entry guard: refuses an idle request when a watchdog interrupt occurs in
// the request cycle or in the cycle before it.
// Assumes wdt_irq is synchronous to clk.
module idle_entry_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic wdt_irq,
    output logic refuse
);
    logic wdt_prev;

    // Purpose: remember whether the watchdog fired in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) wdt_prev <= 1'b0;
        else        wdt_prev <= wdt_irq;
    end

    // Purpose: the refusal window spans this cycle and the last one.
    always_comb refuse = wdt_irq | wdt_prev;

    a_r7_window_tracks_wdt: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq |=> refuse);
endmodule

// File: rtl/idle_release_seq.sv
// Release sequencer: holds the control word (idle, speed), enters idle on
// an accepted request, and on a wake condition clears idle and issues the
// resume pulse, plus a vector request when the master enable is set.
// Assumes wake and wake_idx come from the ungated-clock wake detector.
module idle_release_seq #(
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic            ctl_idle,
    input  logic            ctl_speed,
    input  logic            refuse,
    input  logic            wake,
    input  logic [IDXW-1:0] wake_idx,
    input  logic            master_ie,
    output logic            idle_q,
    output logic            speed_q,
    output logic            resume_q,
    output logic            vec_req_q,
    output logic [IDXW-1:0] vec_idx_q
);
    logic accept_wr;
    logic enter;
    logic release_now;

    // Purpose: decode the request and release conditions of this cycle.
    always_comb begin
        accept_wr   = ctl_wr & ~idle_q;
        enter       = accept_wr & ctl_idle & ~refuse;
        release_now = idle_q & wake;
    end

    // Purpose: control word state; writes are ignored while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q  <= 1'b0;
            speed_q <= 1'b0;
        end else if (release_now) begin
            idle_q  <= 1'b0;
        end else if (accept_wr) begin
            speed_q <= ctl_speed;
            idle_q  <= enter;
        end
    end

    // Purpose: one-cycle resume and vector strobes produced at release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_q  <= 1'b0;
            vec_req_q <= 1'b0;
            vec_idx_q <= '0;
        end else begin
            resume_q  <= release_now;
            vec_req_q <= release_now & master_ie;
            if (release_now) vec_idx_q <= wake_idx;
        end
    end

    a_r3_wake_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q && wake) |=> (!idle_q && resume_q));
    a_r3_no_wake_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q && !wake) |=> (idle_q && !resume_q));
    a_r8_idle_ignores_speed: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q |=> $stable(speed_q));
    a_r4_no_service_release: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q && wake && !master_ie) |=> !vec_req_q);
    a_r5_service_release: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q && wake && master_ie) |=> vec_req_q);
    a_r7_refused_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_q && refuse) |=> !idle_q);
    a_r9_resume_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        resume_q |=> !resume_q);
    a_r9_vec_with_resume: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req_q |-> resume_q);
    a_r6_stall_low_on_resume: assert property (@(posedge clk) disable iff (!rst_n)
        resume_q |-> !idle_q);
endmodule

// File: rtl/idle_wake_ctrl.sv
// Top of the idle entry and wakeup controller. Connects the wake detector,
// the watchdog entry guard and the release sequencer, and forms the
// stall and operating-mode outputs.
// Assumes clk is free running and rst_n is synchronous to it.
module idle_wake_ctrl
    import idle_pkg::*;
#(
    parameter int NSRC = 8,
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic            ctl_idle,
    input  logic            ctl_speed,
    input  logic            wdt_irq,
    input  logic [NSRC-1:0] irq_latch,
    input  logic [NSRC-1:0] irq_enable,
    input  logic            master_ie,
    output logic            cpu_stall,
    output logic            resume_pulse,
    output logic            vec_req,
    output logic [IDXW-1:0] vec_idx,
    output logic [1:0]      op_mode
);
    logic            wake;
    logic [IDXW-1:0] wake_idx;
    logic            refuse;
    logic            idle_q;
    logic            speed_q;
    op_mode_t        mode;

    idle_wake_detect #(.NSRC(NSRC)) u_detect (
        .irq_latch (irq_latch),
        .irq_enable(irq_enable),
        .wake      (wake),
        .wake_idx  (wake_idx)
    );

    idle_entry_guard u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .wdt_irq(wdt_irq),
        .refuse (refuse)
    );

    idle_release_seq #(.IDXW(IDXW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_idle (ctl_idle),
        .ctl_speed(ctl_speed),
        .refuse   (refuse),
        .wake     (wake),
        .wake_idx (wake_idx),
        .master_ie(master_ie),
        .idle_q   (idle_q),
        .speed_q  (speed_q),
        .resume_q (resume_pulse),
        .vec_req_q(vec_req),
        .vec_idx_q(vec_idx)
    );

    // Purpose: expose stall and the {idle, speed} operating mode.
    always_comb begin
        cpu_stall = idle_q;
        mode      = make_mode(idle_q, speed_q);
        op_mode   = mode;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!cpu_stall && !resume_pulse && !vec_req && op_mode == 2'b00));
    a_r2_entry_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stall && ctl_wr && ctl_idle && !refuse) |=> cpu_stall);
endmodule

// File: tb/idle_wake_ctrl_bench.sv
module idle_wake_ctrl_bench;
    localparam int NSRC = 8;
    localparam int IDXW = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            ctl_wr, ctl_idle, ctl_speed, wdt_irq, master_ie;
    logic [NSRC-1:0] irq_latch, irq_enable;
    logic            cpu_stall, resume_pulse, vec_req;
    logic [IDXW-1:0] vec_idx;
    logic [1:0]      op_mode;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic m_idle, m_speed, m_wdtp, m_res, m_vreq;
    logic [IDXW-1:0] m_vidx;

    always #5 clk = ~clk;

    idle_wake_ctrl #(.NSRC(NSRC)) u_idle_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_idle(ctl_idle),
        .ctl_speed(ctl_speed), .wdt_irq(wdt_irq), .irq_latch(irq_latch),
        .irq_enable(irq_enable), .master_ie(master_ie), .cpu_stall(cpu_stall),
        .resume_pulse(resume_pulse), .vec_req(vec_req), .vec_idx(vec_idx),
        .op_mode(op_mode)
    );

    function automatic logic [IDXW-1:0] lowest(input logic [NSRC-1:0] v);
        for (int i = 0; i < NSRC; i++) if (v[i]) return IDXW'(i);
        return '0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        check({tag, " stall"},  int'(cpu_stall),    int'(m_idle));
        check({tag, " mode"},   int'(op_mode),      int'({m_idle, m_speed}));
        check({tag, " resume"}, int'(resume_pulse), int'(m_res));
        check({tag, " vecreq"}, int'(vec_req),      int'(m_vreq));
        if (m_vreq) check({tag, " vecidx"}, int'(vec_idx), int'(m_vidx));
    endtask

    // advance one cycle with the currently driven inputs, then compare
    task automatic step(input string tag);
        logic [NSRC-1:0] hit;
        logic n_idle, n_speed, n_res, n_vreq;
        logic [IDXW-1:0] n_vidx;
        hit = irq_latch & irq_enable;
        n_idle = m_idle; n_speed = m_speed; n_res = 1'b0; n_vreq = 1'b0; n_vidx = m_vidx;
        if (m_idle) begin
            if (|hit) begin
                n_idle = 1'b0; n_res = 1'b1; n_vreq = master_ie; n_vidx = lowest(hit);
            end
        end else if (ctl_wr) begin
            n_speed = ctl_speed;
            n_idle  = ctl_idle & ~wdt_irq & ~m_wdtp;
        end
        @(posedge clk);
        m_idle = n_idle; m_speed = n_speed; m_res = n_res; m_vreq = n_vreq;
        m_vidx = n_vidx; m_wdtp = wdt_irq;
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic quiet();
        ctl_wr = 0; ctl_idle = 0; ctl_speed = 0; wdt_irq = 0;
        irq_latch = '0; irq_enable = '0; master_ie = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        quiet();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_idle = 0; m_speed = 0; m_wdtp = 0; m_res = 0; m_vreq = 0; m_vidx = '0;
        // R1 reset state
        compare_all("R1");
        rst_n = 1;

        // R8: idle=0 write only loads speed
        ctl_wr = 1; ctl_speed = 1; step("R8");
        quiet(); step("R8");
        check("R8 speed", int'(op_mode), 1);

        // R2: enter idle in run mode 1
        ctl_wr = 1; ctl_idle = 1; ctl_speed = 1; step("R2");
        check("R2 stall", int'(cpu_stall), 1);
        quiet();
        // R8: write while idle ignored
        ctl_wr = 1; ctl_speed = 0; ctl_idle = 0; step("R8");
        check("R8 ignored", int'(op_mode), 3);
        quiet();
        // R3: latch without enable does not wake
        irq_latch = 8'h10; irq_enable = 8'h01;
        repeat (4) step("R3");
        check("R3 held", int'(cpu_stall), 1);
        // R4: enabled latch wakes, no service
        irq_enable = 8'h10; master_ie = 0; step("R4");
        check("R4 resume", int'(resume_pulse), 1);
        check("R4 novec", int'(vec_req), 0);
        check("R6 mode", int'(op_mode), 1);
        quiet(); step("R9");
        check("R9 pulse", int'(resume_pulse), 0);

        // R5: service release with lowest index
        ctl_wr = 1; ctl_idle = 1; ctl_speed = 0; step("R5");
        quiet();
        irq_latch = 8'hA4; irq_enable = 8'hFF; master_ie = 1; step("R5");
        check("R5 vecreq", int'(vec_req), 1);
        check("R5 vecidx", int'(vec_idx), 2);
        check("R6 stall", int'(cpu_stall), 0);
        quiet(); step("R9");

        // R7: watchdog one cycle before request
        wdt_irq = 1; step("R7");
        wdt_irq = 0; ctl_wr = 1; ctl_idle = 1; step("R7");
        check("R7 refused prev", int'(cpu_stall), 0);
        quiet();
        // R7: watchdog in request cycle
        ctl_wr = 1; ctl_idle = 1; wdt_irq = 1; step("R7");
        check("R7 refused same", int'(cpu_stall), 0);
        quiet(); step("R7");

        // R1: reset ends idle
        ctl_wr = 1; ctl_idle = 1; ctl_speed = 1; step("R1");
        quiet();
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        m_idle = 0; m_speed = 0; m_wdtp = 0; m_res = 0; m_vreq = 0;
        compare_all("R1");
        rst_n = 1;

        // constrained random
        void'($urandom(32'd1234));
        for (int c = 0; c < 4000; c++) begin
            ctl_wr     = ($urandom % 5) == 0;
            ctl_idle   = ($urandom % 3) != 0;
            ctl_speed  = $urandom % 2;
            wdt_irq    = ($urandom % 8) == 0;
            master_ie  = $urandom % 2;
            irq_latch  = (($urandom % 4) == 0) ? NSRC'($urandom) : '0;
            irq_enable = NSRC'($urandom);
            step("R9");
        end
        quiet(); step("R9");
        finish_run();
    end
endmodule